// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is the multiply-accumulate execution unit of a 64-bit processor. It keeps two 64-bit accumulator registers, HI and LO. On a start pulse it decodes the control bits of the presented instruction word, takes the two operand values read from the register file, multiplies them and adds the product to LO. It then updates both accumulators and hands back a value and a register index for the destination write.

Two control bits pick one of four variants. In the plain forms the unit does a full doubleword multiply-add at 128-bit precision, signed or unsigned. In the saturating forms it multiplies 16-bit operands, adds the product to the low 32 bits of LO and clamps the sum to the 32-bit range. A third bit chooses whether the destination gets the new HI or the new LO. Overflow never raises a trap: plain forms wrap and saturating forms clamp.

The unit is driven by a two-state machine. In `ST_IDLE` it waits. An accepted start moves it to `ST_DONE` (transition *accept*), where it asserts `done` for that cycle. From `ST_DONE` another accepted start keeps it in `ST_DONE` (transition *chain*), and anything else returns it to `ST_IDLE` (transition *retire*). A start with an instruction that is not this operation is ignored in both states.

Top module: `mac_sat_unit`

## Requirements
- R1: A start is accepted only when instruction bits 31:26 are all zero and bits 5:0 equal 101001. Any other start leaves `done` low the next cycle and leaves `hi_q` and `lo_q` unchanged.
- R2: After an accepted start, `done` is high in the next cycle. `hi_q`, `lo_q`, `rd_val` and `rd_idx` take their new values at the same edge. Starts on consecutive cycles each produce one `done` cycle, and `done` is low after a cycle with no accepted start.
- R3: Plain signed form (bit 10 = 0, bit 8 = 0): form the 128-bit signed product of `rs_val` and `rt_val` and add it to the sign-extended LO. The low 64 bits of the sum go to LO and the high 64 bits go to HI. Results wrap, with no trap.
- R4: Plain unsigned form (bit 10 = 0, bit 8 = 1): the same as R3, with both operands and LO zero-extended.
- R5: Saturating signed form (bit 10 = 1, bit 8 = 0): only bits 15:0 of each operand are used, as signed 16-bit values. The product is added to LO bits 31:0 taken as signed. The sum is clamped to the range 0x80000000..0x7FFFFFFF and written to LO sign-extended to 64 bits. A sum that is inside the range, including one equal to a limit, is not altered.
- R6: Saturating unsigned form (bit 10 = 1, bit 8 = 1): operand bits 15:0 and LO bits 31:0 are taken as unsigned. A sum above 0xFFFFFFFF is clamped to 0xFFFFFFFF, and LO receives the result zero-extended.
- R7: In both saturating forms, HI receives the exact unclamped sum, extended to 64 bits.
- R8: When bit 9 is 1, `rd_val` equals the new HI. When it is 0, `rd_val` equals the new LO. `rd_idx` carries instruction bits 15:11.
- R9: After reset `done` is 0, and `hi_q` and `lo_q` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to execute `instr` |
| instr | input | 32 | Instruction word; opcode, function and control bits are decoded |
| rs_val | input | 64 | First operand value |
| rt_val | input | 64 | Second operand value |
| done | output | 1 | High for one cycle per accepted start, the cycle after it |
| rd_idx | output | 5 | Destination register index |
| rd_val | output | 64 | Destination write value (new HI or new LO) |
| hi_q | output | 64 | HI accumulator |
| lo_q | output | 64 | LO accumulator |

## Verification
The bench drives each saturating form across its clamp edges. It walks signed accumulation up past 0x7FFFFFFF and down past 0x80000000, pushes an unsigned sum beyond 0xFFFFFFFF, and adds zero to a saturated LO to hit a limit exactly. A design that compared with the wrong sign, clamped a value sitting at a limit, or extended the unsigned result with ones would show a wrong LO there. It also puts junk in operand bits above 15 and checks HI holds the unclamped sum. This catches a design that used the upper bits or wrote the clamped value into HI. Plain forms are checked with all-ones operands and negative LO values, where a design that mixed up sign and zero extension would produce a wrong HI. Foreign instruction words, back-to-back starts and the HI/LO destination select are checked as well.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam logic [5:0] MAJOR_SPECIAL = 6'b000000;
    localparam logic [5:0] FUNC_MACC     = 6'b101001;
    localparam int         BIT_SAT       = 10;
    localparam int         BIT_HISEL     = 9;
    localparam int         BIT_UNS       = 8;
    localparam int         REGW          = 5;

    typedef struct packed {
        logic            legal;
        logic            sat;
        logic            uns;
        logic            hisel;
        logic [REGW-1:0] rd;
    } mac_ctrl_t;

    typedef enum logic {
        ST_IDLE,
        ST_DONE
    } mac_state_e;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
(
    input  logic [31:0] instr,
    output mac_ctrl_t   ctrl
);

    always_comb begin
        ctrl.legal = (instr[31:26] == MAJOR_SPECIAL) && (instr[5:0] == FUNC_MACC);
        ctrl.sat   = instr[BIT_SAT];
        ctrl.uns   = instr[BIT_UNS];
        ctrl.hisel = instr[BIT_HISEL];
        ctrl.rd    = instr[15:11];
    end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int HALF = 32,
    parameter int OPW  = 16
) (
    input  mac_ctrl_t         ctrl,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    input  logic [XLEN-1:0]   acc_lo,
    output logic [XLEN-1:0]   new_hi,
    output logic [XLEN-1:0]   new_lo
);

    localparam int WW = 2 * XLEN;
    localparam int SW = HALF + 2;

    // Wide path: one (XLEN+1)-bit signed multiplier serves both signedness cases.
    logic                  wa_ext, wb_ext, wl_ext;
    logic signed [XLEN:0]  wa, wb;
    logic signed [WW+1:0]  wprod;
    logic [WW-1:0]         wlo, wsum;

    always_comb begin
        wa_ext = ~ctrl.uns & op_a[XLEN-1];
        wb_ext = ~ctrl.uns & op_b[XLEN-1];
        wl_ext = ~ctrl.uns & acc_lo[XLEN-1];
        wa     = {wa_ext, op_a};
        wb     = {wb_ext, op_b};
        wprod  = (WW+2)'(wa) * (WW+2)'(wb);
        wlo    = {{XLEN{wl_ext}}, acc_lo};
        wsum   = wprod[WW-1:0] + wlo;
    end

    // Narrow path: OPW-bit operands, HALF-bit accumulate, exact SW-bit sum.
    logic                  na_ext, nb_ext, nl_ext;
    logic signed [OPW:0]   na, nb;
    logic signed [HALF:0]  nl;
    logic signed [SW-1:0]  nprod, nsum;
    logic [HALF-1:0]       nclamp;
    logic                  ovf_s, ovf_u;

    always_comb begin
        na_ext = ~ctrl.uns & op_a[OPW-1];
        nb_ext = ~ctrl.uns & op_b[OPW-1];
        nl_ext = ~ctrl.uns & acc_lo[HALF-1];
        na     = {na_ext, op_a[OPW-1:0]};
        nb     = {nb_ext, op_b[OPW-1:0]};
        nl     = {nl_ext, acc_lo[HALF-1:0]};
        nprod  = SW'(na) * SW'(nb);
        nsum   = nprod + SW'(nl);
        ovf_s  = (nsum[SW-1:HALF-1] != {(SW-HALF+1){1'b0}}) &&
                 (nsum[SW-1:HALF-1] != {(SW-HALF+1){1'b1}});
        ovf_u  = (nsum[SW-1:HALF] != {(SW-HALF){1'b0}});
        if (ctrl.uns) begin
            nclamp = ovf_u ? {HALF{1'b1}} : nsum[HALF-1:0];
        end else if (ovf_s) begin
            nclamp = nsum[SW-1] ? {1'b1, {(HALF-1){1'b0}}} : {1'b0, {(HALF-1){1'b1}}};
        end else begin
            nclamp = nsum[HALF-1:0];
        end
    end

    // Variant select: HI gets exact sum in saturating forms.
    always_comb begin
        if (ctrl.sat) begin
            new_lo = ctrl.uns ? {{(XLEN-HALF){1'b0}}, nclamp}
                              : {{(XLEN-HALF){nclamp[HALF-1]}}, nclamp};
            new_hi = {{(XLEN-SW){nsum[SW-1]}}, nsum};
        end else begin
            new_lo = wsum[XLEN-1:0];
            new_hi = wsum[WW-1:XLEN];
        end
    end

    // R6: an unsigned clamped value never exceeds the exact sum
    always_comb begin
        a_r6_clamp_bound: assert (!(ctrl.sat && ctrl.uns) ||
                                  ({{(SW-HALF){1'b0}}, nclamp} <= nsum))
            else $error("a_r6_clamp_bound");
    end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int HALF = 32,
    parameter int OPW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            done,
    output logic [REGW-1:0] rd_idx,
    output logic [XLEN-1:0] rd_val,
    output logic [XLEN-1:0] hi_q,
    output logic [XLEN-1:0] lo_q
);

    mac_ctrl_t       ctrl;
    logic            accept;
    logic [XLEN-1:0] nxt_hi, nxt_lo;
    mac_state_e      state, state_nxt;
    logic            sel_q, sat_q, uns_q;

    mac_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    mac_datapath #(
        .XLEN (XLEN),
        .HALF (HALF),
        .OPW  (OPW)
    ) u_dp (
        .ctrl   (ctrl),
        .op_a   (rs_val),
        .op_b   (rt_val),
        .acc_lo (lo_q),
        .new_hi (nxt_hi),
        .new_lo (nxt_lo)
    );

    assign accept = start & ctrl.legal;

    // Next-state logic: accept, chain, retire.
    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = accept ? ST_DONE : ST_IDLE;
            ST_DONE: state_nxt = accept ? ST_DONE : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Accumulators and destination result, written on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            rd_val <= '0;
            rd_idx <= '0;
            sel_q  <= 1'b0;
            sat_q  <= 1'b0;
            uns_q  <= 1'b0;
        end else if (accept) begin
            hi_q   <= nxt_hi;
            lo_q   <= nxt_lo;
            rd_val <= ctrl.hisel ? nxt_hi : nxt_lo;
            rd_idx <= ctrl.rd;
            sel_q  <= ctrl.hisel;
            sat_q  <= ctrl.sat;
            uns_q  <= ctrl.uns;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state)
            ST_IDLE: done = 1'b0;
            ST_DONE: done = 1'b1;
            default: done = 1'b0;
        endcase
    end

    a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ctrl.legal) |=> done);

    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && ctrl.legal) |=> !done);

    a_r1_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && ctrl.legal) |=> ($stable(hi_q) && $stable(lo_q)));

    a_r8_rd_select: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_val == (sel_q ? hi_q : lo_q)));

    a_r6_lo_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sat_q && uns_q) |-> (lo_q[XLEN-1:HALF] == '0));

    a_r5_lo_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sat_q && !uns_q) |-> (lo_q[XLEN-1:HALF] == {(XLEN-HALF){lo_q[HALF-1]}}));

endmodule

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rs_val = '0, rt_val = '0;
    logic        done;
    logic [4:0]  rd_idx;
    logic [63:0] rd_val, hi_q, lo_q;

    int errors = 0;
    int checks = 0;

    logic [63:0] m_hi = '0, m_lo = '0;

    logic [4:0]  q_rd[$];
    logic [63:0] q_val[$], q_hi[$], q_lo[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    mac_sat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .done(done), .rd_idx(rd_idx),
        .rd_val(rd_val), .hi_q(hi_q), .lo_q(lo_q)
    );

    function automatic logic [31:0] mk(input logic sat, input logic uns,
                                       input logic hs, input logic [4:0] rd);
        return {6'b000000, 5'd3, 5'd4, rd, sat, hs, uns, 2'b00, 6'b101001};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model from the requirements.
    task automatic model(input logic sat, input logic uns,
                         input logic [63:0] a, input logic [63:0] b);
        if (sat) begin
            longint xa, xb, xl, s, c;
            xa = uns ? longint'({48'b0, a[15:0]}) : longint'($signed(a[15:0]));
            xb = uns ? longint'({48'b0, b[15:0]}) : longint'($signed(b[15:0]));
            xl = uns ? longint'({32'b0, m_lo[31:0]}) : longint'($signed(m_lo[31:0]));
            s  = xa * xb + xl;
            c  = s;
            if (uns) begin
                if (s > 64'sh0_FFFF_FFFF) c = 64'sh0_FFFF_FFFF;
                m_lo = {32'b0, c[31:0]};
            end else begin
                if (s > 64'sh7FFF_FFFF) c = 64'sh7FFF_FFFF;
                if (s < -64'sh8000_0000) c = -64'sh8000_0000;
                m_lo = {{32{c[31]}}, c[31:0]};
            end
            m_hi = s;
        end else begin
            logic [127:0] pa, pb, pl, sum;
            pa  = uns ? {64'b0, a} : {{64{a[63]}}, a};
            pb  = uns ? {64'b0, b} : {{64{b[63]}}, b};
            pl  = uns ? {64'b0, m_lo} : {{64{m_lo[63]}}, m_lo};
            sum = pa * pb + pl;
            m_lo = sum[63:0];
            m_hi = sum[127:64];
        end
    endtask

    // Driver: pushes expected item, asserts start for one cycle.
    task automatic issue(input string tag, input logic sat, input logic uns,
                         input logic hs, input logic [4:0] rd,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        instr  = mk(sat, uns, hs, rd);
        rs_val = a;
        rt_val = b;
        start  = 1'b1;
        model(sat, uns, a, b);
        q_rd.push_back(rd);
        q_val.push_back(hs ? m_hi : m_lo);
        q_hi.push_back(m_hi);
        q_lo.push_back(m_lo);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: pops and compares on every done cycle.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_tag.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2: actual=done expected=no done (no pending item)");
            end else begin
                string t;
                logic [63:0] ev, eh, el;
                logic [4:0]  er;
                t  = q_tag.pop_front();
                ev = q_val.pop_front();
                eh = q_hi.pop_front();
                el = q_lo.pop_front();
                er = q_rd.pop_front();
                chk({t, " HI"}, hi_q, eh);
                chk({t, " LO"}, lo_q, el);
                chk({t, " R8 rd_val"}, rd_val, ev);
                chk({t, " R8 rd_idx"}, {59'b0, rd_idx}, {59'b0, er});
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 done", {63'b0, done}, 64'd0);
        chk("R9 hi", hi_q, 64'd0);
        chk("R9 lo", lo_q, 64'd0);

        // R5: signed saturating climb to positive clamp, junk in upper bits
        issue("R5 climb1", 1, 0, 0, 5'd7, 64'hDEAD_BEEF_0000_7FFF, 64'h1234_0000_5555_7FFF);
        idle();
        issue("R5 climb2", 1, 0, 1, 5'd8, 64'h0000_0000_0000_7FFF, 64'hFFFF_FFFF_FFFF_7FFF);
        idle();
        issue("R5 R7 clamp hi", 1, 0, 1, 5'd9, 64'h7FFF, 64'h7FFF);
        idle();
        chk("R5 positive clamp", lo_q, 64'h0000_0000_7FFF_FFFF);
        chk("R7 exact sum", hi_q, 64'h0000_0000_BFFD_0003);
        // R5: add zero at the limit, no change
        issue("R5 at limit", 1, 0, 0, 5'd10, 64'hABCD_0000, 64'h1234);
        idle();
        chk("R5 limit kept", lo_q, 64'h0000_0000_7FFF_FFFF);
        // R5: walk down to negative clamp
        for (int i = 0; i < 5; i++) begin
            issue("R5 descend", 1, 0, i[0], 5'd11, 64'h8000, 64'h7FFF);
        end
        idle();
        chk("R5 negative clamp", lo_q, 64'hFFFF_FFFF_8000_0000);
        // R6: unsigned saturating overflow
        issue("R6 R7 unsigned clamp", 1, 1, 0, 5'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_FFFF);
        idle();
        chk("R6 clamp", lo_q, 64'h0000_0000_FFFF_FFFF);
        chk("R7 unsigned exact", hi_q, 64'h0000_0001_7FFE_0001);
        // R1: foreign function code and foreign major opcode ignored
        @(negedge clk);
        instr = mk(1, 1, 0, 5'd1) ^ 32'h0000_0001;
        rs_val = 64'h1; rt_val = 64'h1; start = 1'b1;
        @(negedge clk);
        chk("R1 no done (func)", {63'b0, done}, 64'd0);
        instr = mk(0, 0, 0, 5'd1) | 32'h0400_0000;
        @(negedge clk);
        chk("R1 no done (major)", {63'b0, done}, 64'd0);
        chk("R1 lo held", lo_q, m_lo);
        chk("R1 hi held", hi_q, m_hi);
        start = 1'b0;
        // R3: plain signed with negative operand
        issue("R3 signed", 0, 0, 1, 5'd13, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5);
        // R4: plain unsigned, all ones, back to back (R2)
        issue("R4 R2 unsigned", 0, 1, 1, 5'd14, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
        issue("R3 R2 wrap", 0, 0, 0, 5'd15, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        idle();
        @(negedge clk);
        chk("R2 done drops", {63'b0, done}, 64'd0);
        // Mixed sweep over all variants
        for (int i = 0; i < 40; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            issue("R3 R4 R5 R6 sweep", i[1], i[2], i[0], 5'(i), a, b);
            if (i[3]) idle();
        end
        idle();
        repeat (3) @(negedge clk);
        chk("R2 queue drained", 64'(q_tag.size()), 64'd0);
        finish_run();
    end

endmodule